// File: doc/BRIEF.md
# Gaussian Log-Likelihood Transition Metric Unit

This block scores one hidden-Markov-model state for a speech recogniser that works with negative logarithms. A start pulse latches the state's two log transition costs (self-loop and forward). The block then takes a stream of parameter beats, one feature dimension per beat. Each beat carries the observation component, the mixture mean, the inverse-variance weight and the mixture constant. For every mixture it adds up a weighted squared distance and then adds that mixture's constant. It keeps the smallest of these mixture scores, adds each transition cost to it, and emits the two metrics with a one-cycle valid strobe.

The beat datapath runs as a three-stage pipeline: absolute difference, square, weight. An accumulator follows it and closes a mixture score on the final dimension of that mixture. A running minimum register folds the scores in as they leave the pipeline, so the minimum search overlaps with the distance work for later mixtures. To score the states of one model back to back, the caller issues one start per state. Parameter storage, feature extraction and the path-metric recursion live outside this block.

The controller has four states. IDLE waits for start. LOAD accepts beats. DRAIN waits for the last mixture score to leave the pipeline. EMIT presents the result for one cycle. The transitions are: IDLE to LOAD on start; LOAD to DRAIN when the final beat is accepted; DRAIN to EMIT when the final mixture score is folded in; EMIT to IDLE unconditionally.

Top module: `gmm_trans_metric`

## Requirements
- R1: After reset, in_ready and out_valid are both 0.
- R2: A start pulse in IDLE latches a_self and a_fwd and raises in_ready on the next cycle. Exactly M·D beats are then accepted (accepted means in_valid and in_ready both high at a rising edge), and in_ready is 0 in the cycle after the final beat. While in_ready is 0, in_valid has no effect.
- R3: Beats are ordered with the dimension index varying fastest, then the mixture index. in_const is sampled only on the beat carrying dimension D-1 of each mixture.
- R4: A mixture score is in_const plus the sum over the D dimensions of in_wt·|in_obs − in_mean|², computed on unsigned integers without loss.
- R5: The observation cost is the smallest of the M mixture scores.
- R6: out_self = a_self + cost and out_fwd = a_fwd + cost, each clamped to 2^MW−1 (65535 by default) when the true sum exceeds it.
- R7: out_valid is a single-cycle pulse. It is high in the cycle that follows the third rising edge after the edge that accepted the final beat, and the unit is back in IDLE after it.
- R8: Idle cycles on in_valid between beats do not change the result.
- R9: Every start resets the running minimum to all ones, so a result never depends on an earlier state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin scoring a state (acted on in IDLE only) |
| a_self | input | MW | Self-loop negative-log transition cost |
| a_fwd | input | MW | Forward negative-log transition cost |
| in_valid | input | 1 | Beat present |
| in_ready | output | 1 | Beat accepted this cycle if in_valid |
| in_obs | input | FW | Observation component for this dimension |
| in_mean | input | FW | Mixture mean for this dimension |
| in_wt | input | WW | Inverse-variance weight for this dimension |
| in_const | input | CW | Mixture constant, used on the last dimension beat |
| out_valid | output | 1 | Result strobe |
| out_self | output | MW | Saturated self-loop metric |
| out_fwd | output | MW | Saturated forward metric |

## Verification
Two functions can fall in the same clock edge. When beats arrive with no gap, one mixture's final product is closed into a score and folded into the minimum on the same edge that the next mixture's first product starts a fresh accumulation. Gapless streams with the smallest score placed in the middle mixture provoke this case. The result is judged against a reference score computed in the bench, and then against a run of the same data with idle cycles inserted.

// File: rtl/gtm_pkg.sv
package gtm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_DRAIN,
        ST_EMIT
    } gtm_state_e;
endpackage

// File: rtl/gtm_dist_pipe.sv
// Difference / square / weight pipeline followed by a per-mixture accumulator.
module gtm_dist_pipe #(
    parameter int FW = 8,
    parameter int WW = 8,
    parameter int CW = 16,
    parameter int D  = 4,
    parameter int SW = 27
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          beat_v,
    input  logic          beat_last,
    input  logic [FW-1:0] obs,
    input  logic [FW-1:0] mean,
    input  logic [WW-1:0] wt,
    input  logic [CW-1:0] cst,
    output logic          sc_valid,
    output logic [SW-1:0] sc
);
    localparam int PW = 2*FW + WW;
    localparam int AW = PW + $clog2(D) + 1;

    logic          v1, v2, v3;
    logic          l1, l2, l3;
    logic [CW-1:0] c1, c2, c3;
    logic [WW-1:0] w1, w2;
    logic [FW-1:0] d1;
    logic [2*FW-1:0] sq2;
    logic [PW-1:0] p3;
    logic [AW-1:0] acc_q;
    logic [AW-1:0] sum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
            l1 <= 1'b0; l2 <= 1'b0; l3 <= 1'b0;
            c1 <= '0; c2 <= '0; c3 <= '0;
            w1 <= '0; w2 <= '0;
            d1 <= '0; sq2 <= '0; p3 <= '0;
            acc_q <= '0;
        end else begin
            v1  <= beat_v;
            l1  <= beat_last;
            c1  <= cst;
            w1  <= wt;
            d1  <= (obs >= mean) ? (obs - mean) : (mean - obs);
            v2  <= v1;
            l2  <= l1;
            c2  <= c1;
            w2  <= w1;
            sq2 <= d1 * d1;
            v3  <= v2;
            l3  <= l2;
            c3  <= c2;
            p3  <= sq2 * w2;
            if (v3) begin
                acc_q <= l3 ? '0 : sum;
            end
        end
    end

    always_comb begin
        sum      = acc_q + AW'(p3);
        sc_valid = v3 & l3;
        sc       = SW'(sum) + SW'(c3);
    end
endmodule

// File: rtl/gtm_min_sat.sv
// Running minimum over mixture scores, then saturated addition of both costs.
module gtm_min_sat #(
    parameter int SW = 27,
    parameter int MW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          sc_valid,
    input  logic [SW-1:0] sc,
    input  logic [MW-1:0] a_self,
    input  logic [MW-1:0] a_fwd,
    output logic [MW-1:0] out_self,
    output logic [MW-1:0] out_fwd
);
    localparam logic [SW:0] MAXV = (SW+1)'({MW{1'b1}});

    logic [SW-1:0] minr;
    logic [SW:0]   s_self, s_fwd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            minr <= '1;
        end else if (clr) begin
            minr <= '1;
        end else if (sc_valid && (sc < minr)) begin
            minr <= sc;
        end
    end

    always_comb begin
        s_self   = {1'b0, minr} + (SW+1)'(a_self);
        s_fwd    = {1'b0, minr} + (SW+1)'(a_fwd);
        out_self = (s_self > MAXV) ? '1 : s_self[MW-1:0];
        out_fwd  = (s_fwd  > MAXV) ? '1 : s_fwd[MW-1:0];
    end

    AST_MIN_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid && !clr) |=> (minr <= $past(minr)));   // R5

    AST_SAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((out_self >= a_self) && (out_fwd >= a_fwd)));  // R6
endmodule

// File: rtl/gmm_trans_metric.sv
module gmm_trans_metric #(
    parameter int FW = 8,
    parameter int WW = 8,
    parameter int CW = 16,
    parameter int MW = 16,
    parameter int D  = 4,
    parameter int M  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [MW-1:0] a_self,
    input  logic [MW-1:0] a_fwd,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [FW-1:0] in_obs,
    input  logic [FW-1:0] in_mean,
    input  logic [WW-1:0] in_wt,
    input  logic [CW-1:0] in_const,
    output logic          out_valid,
    output logic [MW-1:0] out_self,
    output logic [MW-1:0] out_fwd
);
    import gtm_pkg::*;

    localparam int PW  = 2*FW + WW;
    localparam int AW  = PW + $clog2(D) + 1;
    localparam int SW  = ((AW > CW) ? AW : CW) + 1;
    localparam int DIW = (D > 1) ? $clog2(D) : 1;
    localparam int MIW = (M > 1) ? $clog2(M) : 1;
    localparam int NIW = $clog2(M + 1);

    gtm_state_e     state_q, state_d;
    logic [DIW-1:0] dim_q;
    logic [MIW-1:0] mix_q;
    logic [NIW-1:0] done_q;
    logic [MW-1:0]  as_q, af_q;
    logic           fire, last_dim, last_beat, clr;
    logic           sc_valid;
    logic [SW-1:0]  sc;

    assign fire      = in_valid & in_ready;
    assign last_dim  = (dim_q == DIW'(D-1));
    assign last_beat = last_dim && (mix_q == MIW'(M-1));
    assign clr       = start && (state_q == ST_IDLE);

    // State register and bookkeeping counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dim_q   <= '0;
            mix_q   <= '0;
            done_q  <= '0;
            as_q    <= '0;
            af_q    <= '0;
        end else begin
            state_q <= state_d;
            if (clr) begin
                dim_q  <= '0;
                mix_q  <= '0;
                done_q <= '0;
                as_q   <= a_self;
                af_q   <= a_fwd;
            end else begin
                if (fire) begin
                    dim_q <= last_dim ? '0 : dim_q + 1'b1;
                    if (last_dim) mix_q <= mix_q + 1'b1;
                end
                if (sc_valid) done_q <= done_q + 1'b1;
            end
        end
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_LOAD;
            ST_LOAD:  if (fire && last_beat) state_d = ST_DRAIN;
            ST_DRAIN: if (sc_valid && (done_q == NIW'(M-1))) state_d = ST_EMIT;
            ST_EMIT:  state_d = ST_IDLE;
        endcase
    end

    // Handshake outputs.
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_LOAD:  in_ready = 1'b1;
            ST_DRAIN: ;
            ST_EMIT:  out_valid = 1'b1;
        endcase
    end

    gtm_dist_pipe #(.FW(FW), .WW(WW), .CW(CW), .D(D), .SW(SW)) u_dist (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_v    (fire),
        .beat_last (last_dim),
        .obs       (in_obs),
        .mean      (in_mean),
        .wt        (in_wt),
        .cst       (in_const),
        .sc_valid  (sc_valid),
        .sc        (sc)
    );

    gtm_min_sat #(.SW(SW), .MW(MW)) u_min (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .sc_valid (sc_valid),
        .sc       (sc),
        .a_self   (as_q),
        .a_fwd    (af_q),
        .out_self (out_self),
        .out_fwd  (out_fwd)
    );

    AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> in_ready);                               // R2

    AST_BEAT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && last_beat) |=> !in_ready);              // R2

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);                       // R7
endmodule

// File: tb/gmm_trans_metric_tb.sv
`timescale 1ns/1ps
module gmm_trans_metric_tb;
    localparam int D = 4;
    localparam int M = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] a_self = '0, a_fwd = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_obs = '0, in_mean = '0, in_wt = '0;
    logic [15:0] in_const = '0;
    logic        out_valid;
    logic [15:0] out_self, out_fwd;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0]  obs [D];
    logic [7:0]  mu  [M][D];
    logic [7:0]  wt  [M][D];
    logic [15:0] cst [M];

    always #4 clk = ~clk;   // 125 MHz

    gmm_trans_metric u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .a_self(a_self), .a_fwd(a_fwd),
        .in_valid(in_valid), .in_ready(in_ready), .in_obs(in_obs), .in_mean(in_mean),
        .in_wt(in_wt), .in_const(in_const), .out_valid(out_valid),
        .out_self(out_self), .out_fwd(out_fwd)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint ref_cost();
        longint best = -1;
        for (int j = 0; j < M; j++) begin
            longint s = cst[j];
            for (int k = 0; k < D; k++) begin
                longint df = (obs[k] >= mu[j][k]) ? obs[k] - mu[j][k] : mu[j][k] - obs[k];
                s += longint'(wt[j][k]) * df * df;
            end
            if (best < 0 || s < best) best = s;
        end
        return best;
    endfunction

    function automatic longint sat16(input longint v);
        return (v > 65535) ? 65535 : v;
    endfunction

    // Score one state; gap>0 inserts idle cycles before each beat; garbage const on non-final dims.
    task automatic run_state(input logic [15:0] as_v, input logic [15:0] af_v,
                             input int gap, input string req);
        longint cost = ref_cost();
        int lat = 0;
        @(negedge clk);
        start = 1'b1; a_self = as_v; a_fwd = af_v;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0; a_self = 16'hFFFF; a_fwd = 16'hFFFF;
        chk(in_ready == 1'b1, "R2 ready after start", in_ready, 1);
        for (int j = 0; j < M; j++) begin
            for (int k = 0; k < D; k++) begin
                for (int g = 0; g < gap; g++) begin
                    in_valid = 1'b0;
                    in_obs = 8'hAA; in_mean = 8'h00; in_wt = 8'hFF;
                    @(negedge clk);
                end
                in_valid = 1'b1;
                in_obs = obs[k]; in_mean = mu[j][k]; in_wt = wt[j][k];
                in_const = (k == D-1) ? cst[j] : 16'hBEEF;
                @(posedge clk);
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R2 ready drops after M*D beats", in_ready, 0);
        for (int t = 0; t < 10; t++) begin
            if (out_valid) break;
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        chk(lat == 3, "R7 latency", lat, 3);
        chk(out_self == sat16(longint'(as_v) + cost), {req, " out_self"}, out_self, sat16(longint'(as_v) + cost));
        chk(out_fwd == sat16(longint'(af_v) + cost), {req, " out_fwd"}, out_fwd, sat16(longint'(af_v) + cost));
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 single pulse", out_valid, 0);
        chk(in_ready == 1'b0, "R7 back to idle", in_ready, 0);
    endtask

    task automatic load_basic();
        for (int k = 0; k < D; k++) obs[k] = 8'(20 + 10*k);
        for (int j = 0; j < M; j++) begin
            for (int k = 0; k < D; k++) begin
                mu[j][k] = 8'(obs[k] + (j == 1 ? 1 : -3*(j+1)));   // below and above obs: R4 abs diff
                wt[j][k] = 8'(2 + j + k);
            end
        end
        cst[0] = 16'd40; cst[1] = 16'd25; cst[2] = 16'd10;   // middle mixture smallest: R5
    endtask

    task automatic test_reset();
        chk(in_ready == 1'b0, "R1 in_ready", in_ready, 0);
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    endtask

    task automatic test_basic();
        load_basic();
        run_state(16'd100, 16'd300, 0, "R4 R5 R6 R3 gapless");
    endtask

    task automatic test_stalls();
        load_basic();
        run_state(16'd100, 16'd300, 2, "R8 stalled");
    endtask

    task automatic test_saturate();
        load_basic();
        for (int k = 0; k < D; k++) begin
            mu[0][k] = 8'd0; wt[0][k] = 8'd1;
        end
        obs[0] = 8'd120; obs[1] = 8'd0; obs[2] = 8'd0; obs[3] = 8'd0;
        for (int j = 1; j < M; j++) for (int k = 0; k < D; k++) begin
            mu[j][k] = 8'd255; wt[j][k] = 8'd255;
        end
        cst[0] = 16'd46000;   // cost 60400
        run_state(16'd100, 16'd9000, 0, "R6 saturation");
    endtask

    task automatic test_clear();
        for (int k = 0; k < D; k++) obs[k] = 8'd0;
        for (int j = 0; j < M; j++) for (int k = 0; k < D; k++) begin
            mu[j][k] = 8'd1; wt[j][k] = 8'd1;
        end
        cst[0] = 16'd5; cst[1] = 16'd7; cst[2] = 16'd9;
        run_state(16'd1, 16'd2, 0, "R9 first state");
        for (int j = 0; j < M; j++) for (int k = 0; k < D; k++) mu[j][k] = 8'd9;
        cst[0] = 16'd500; cst[1] = 16'd600; cst[2] = 16'd700;   // all scores larger than before
        run_state(16'd1, 16'd2, 1, "R9 second state");
    endtask

    task automatic test_idle_ignored();
        @(negedge clk);
        in_valid = 1'b1; in_const = 16'd1;
        repeat (5) @(negedge clk);
        chk(in_ready == 1'b0, "R2 idle ready", in_ready, 0);
        chk(out_valid == 1'b0, "R2 idle no output", out_valid, 0);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_basic();
        test_stalls();
        test_saturate();
        test_clear();
        test_idle_ignored();
        done = 1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule